// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

A small fully associative store of finished address translations. Each slot is keyed by a 16-bit address space identifier together with an input address. It holds the output address, a mask equal to the granule size minus one, and the permission bits of that translation. A lookup compares its key against every slot at once. The result (hit flag and stored data) comes back from registers one cycle after the request.

Completed walks are written in through a fill port. A fill whose key is already present overwrites that slot in place. Otherwise the lowest-numbered empty slot is used. When every slot is occupied, a round-robin pointer names the victim.

Three invalidation commands keep the cache coherent with changed tables: drop everything, drop one identifier's entries, or drop a single identifier-and-address pair. Reset leaves the cache empty.

Top module: `xlat_cache`

## Requirements
- R1: After reset, and after any later reset, every lookup misses until a new fill is made.
- R2: A lookup whose identifier and address both equal those of a stored entry hits. lk_hit, lk_oa, lk_mask and lk_perm are then valid on the clock edge after the request, with lk_done high for exactly that one cycle.
- R3: A lookup misses if only one of identifier or address matches a stored entry. On a miss, lk_oa, lk_mask and lk_perm read zero.
- R4: Invalidation kind 2'b00 removes every entry.
- R5: Invalidation kind 2'b01 removes every entry whose identifier equals inv_id, whatever its address, and keeps entries of other identifiers.
- R6: Invalidation kind 2'b10 removes only the entry whose identifier and address both equal inv_id and inv_addr.
- R7: A fill with a new key goes to the lowest-numbered empty slot. With all ENTRIES slots full, it replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each such replacement.
- R8: A fill whose key is already stored overwrites that entry's data, so that no key is ever held twice.
- R9: A fill in the same cycle as any invalidation command is discarded.
- R10: A lookup issued in the cycle after an invalidation never hits an entry that the invalidation removed.
- R11: Invalidation kind 2'b11 changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_id | input | ID_W | Lookup address space identifier |
| lk_addr | input | VA_W | Lookup input address |
| lk_done | output | 1 | Lookup result valid (one cycle after lk_req) |
| lk_hit | output | 1 | Lookup hit |
| lk_oa | output | OA_W | Output address of the hit entry |
| lk_mask | output | OA_W | Address mask of the hit entry |
| lk_perm | output | PERM_W | Permissions of the hit entry |
| fill_en | input | 1 | Write a completed translation |
| fill_id | input | ID_W | Identifier of the fill |
| fill_addr | input | VA_W | Input address of the fill |
| fill_oa | input | OA_W | Output address to store |
| fill_mask | input | OA_W | Mask to store (granule size minus one) |
| fill_perm | input | PERM_W | Permissions to store |
| inv_en | input | 1 | Invalidation command strobe |
| inv_kind | input | 2 | 00 all, 01 by identifier, 10 by identifier and address, 11 none |
| inv_id | input | ID_W | Identifier operand of the invalidation |
| inv_addr | input | VA_W | Address operand of by-key invalidation |

## Verification
The only result with its own latency is the lookup. Its hit flag and data are due on the edge after the request, and they reflect the entries as they stood before that edge's fill or invalidation. Fills and invalidations change the slots on the edge that samples them, so they become visible to a lookup issued in the next cycle. The bench drives every input on the falling edge. At the rising edge it computes the expected lookup from its model, then applies the fill or invalidation to the model, and it compares on the next falling edge. Random traffic over a key space twice the cache size provokes evictions and overwrites. Directed sequences pin down the replacement order, the fill-versus-invalidation priority and the no-op command.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      INV_ALL  = 2'b00,
      INV_ID   = 2'b01,
      INV_KEY  = 2'b10,
      INV_NONE = 2'b11
   } inv_kind_e;

endpackage

// File: rtl/xlat_match.sv
// One slot's key comparators: lookup, fill and both invalidation forms.
module xlat_match #(
   parameter int ID_W = 16,
   parameter int VA_W = 48
) (
   input  logic            vld,
   input  logic [ID_W-1:0] e_id,
   input  logic [VA_W-1:0] e_addr,
   input  logic [ID_W-1:0] lk_id,
   input  logic [VA_W-1:0] lk_addr,
   input  logic [ID_W-1:0] fl_id,
   input  logic [VA_W-1:0] fl_addr,
   input  logic [ID_W-1:0] iv_id,
   input  logic [VA_W-1:0] iv_addr,
   output logic            lk_hit,
   output logic            fl_hit,
   output logic            iv_id_hit,
   output logic            iv_key_hit
);
   logic iv_id_eq;

   assign lk_hit     = vld && (e_id == lk_id) && (e_addr == lk_addr);
   assign fl_hit     = vld && (e_id == fl_id) && (e_addr == fl_addr);
   assign iv_id_eq   = vld && (e_id == iv_id);
   assign iv_id_hit  = iv_id_eq;
   assign iv_key_hit = iv_id_eq && (e_addr == iv_addr);
endmodule

// File: rtl/xlat_victim.sv
// Chooses the slot a fill writes: existing key, else lowest empty, else round-robin.
module xlat_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] vld,
   input  logic [ENTRIES-1:0] same_key,
   input  logic [IDX_W-1:0]   rr_ptr,
   output logic [IDX_W-1:0]   slot,
   output logic               evict
);
   logic [IDX_W-1:0] key_idx;
   logic [IDX_W-1:0] free_idx;

   always_comb begin
      key_idx  = '0;
      free_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (same_key[e]) key_idx = IDX_W'(e);
         if (!vld[e])     free_idx = IDX_W'(e);
      end
   end

   always_comb begin
      if (|same_key) begin
         slot  = key_idx;
         evict = 1'b0;
      end else if (!(&vld)) begin
         slot  = free_idx;
         evict = 1'b0;
      end else begin
         slot  = rr_ptr;
         evict = 1'b1;
      end
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int ID_W    = 16,
   parameter int VA_W    = 48,
   parameter int OA_W    = 48,
   parameter int PERM_W  = 2,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [ID_W-1:0]   lk_id,
   input  logic [VA_W-1:0]   lk_addr,
   output logic              lk_done,
   output logic              lk_hit,
   output logic [OA_W-1:0]   lk_oa,
   output logic [OA_W-1:0]   lk_mask,
   output logic [PERM_W-1:0] lk_perm,
   input  logic              fill_en,
   input  logic [ID_W-1:0]   fill_id,
   input  logic [VA_W-1:0]   fill_addr,
   input  logic [OA_W-1:0]   fill_oa,
   input  logic [OA_W-1:0]   fill_mask,
   input  logic [PERM_W-1:0] fill_perm,
   input  logic              inv_en,
   input  logic [1:0]        inv_kind,
   input  logic [ID_W-1:0]   inv_id,
   input  logic [VA_W-1:0]   inv_addr
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be at least 2");
   end
   if (ID_W < 1 || VA_W < 1 || OA_W < 1 || PERM_W < 1) begin : g_bad_width
      $error("xlat_cache: all widths must be positive");
   end

   // slot state
   logic [ENTRIES-1:0] vld_q;
   logic [ID_W-1:0]    id_q   [ENTRIES];
   logic [VA_W-1:0]    addr_q [ENTRIES];
   logic [OA_W-1:0]    oa_q   [ENTRIES];
   logic [OA_W-1:0]    mask_q [ENTRIES];
   logic [PERM_W-1:0]  perm_q [ENTRIES];
   logic [IDX_W-1:0]   rr_q;

   // per-slot comparisons
   logic [ENTRIES-1:0] lk_vec;
   logic [ENTRIES-1:0] fl_vec;
   logic [ENTRIES-1:0] iid_vec;
   logic [ENTRIES-1:0] ikey_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      xlat_match #(.ID_W(ID_W), .VA_W(VA_W)) u_match (
         .vld       (vld_q[e]),
         .e_id      (id_q[e]),
         .e_addr    (addr_q[e]),
         .lk_id     (lk_id),
         .lk_addr   (lk_addr),
         .fl_id     (fill_id),
         .fl_addr   (fill_addr),
         .iv_id     (inv_id),
         .iv_addr   (inv_addr),
         .lk_hit    (lk_vec[e]),
         .fl_hit    (fl_vec[e]),
         .iv_id_hit (iid_vec[e]),
         .iv_key_hit(ikey_vec[e])
      );
   end

   // invalidation decode: slots to clear this cycle
   inv_kind_e          kind;
   logic [ENTRIES-1:0] kill_vec;

   assign kind = inv_kind_e'(inv_kind);

   always_comb begin
      kill_vec = '0;
      if (inv_en) begin
         unique case (kind)
            INV_ALL:  kill_vec = '1;
            INV_ID:   kill_vec = iid_vec;
            INV_KEY:  kill_vec = ikey_vec;
            INV_NONE: kill_vec = '0;
         endcase
      end
   end

   // fill placement; invalidation wins over a fill in the same cycle
   logic [IDX_W-1:0] fl_slot;
   logic             fl_evict;
   logic             do_fill;

   xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
      .vld     (vld_q),
      .same_key(fl_vec),
      .rr_ptr  (rr_q),
      .slot    (fl_slot),
      .evict   (fl_evict)
   );

   assign do_fill = fill_en && !inv_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         rr_q  <= '0;
      end else begin
         vld_q <= vld_q & ~kill_vec;
         if (do_fill) begin
            vld_q[fl_slot] <= 1'b1;
            if (fl_evict) begin
               rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_fill) begin
         id_q[fl_slot]   <= fill_id;
         addr_q[fl_slot] <= fill_addr;
         oa_q[fl_slot]   <= fill_oa;
         mask_q[fl_slot] <= fill_mask;
         perm_q[fl_slot] <= fill_perm;
      end
   end

   // lookup data select (one-hot and-or) and result register
   logic [OA_W-1:0]   sel_oa;
   logic [OA_W-1:0]   sel_mask;
   logic [PERM_W-1:0] sel_perm;
   logic              any_hit;

   always_comb begin
      sel_oa   = '0;
      sel_mask = '0;
      sel_perm = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         sel_oa   = sel_oa   | (oa_q[e]   & {OA_W{lk_vec[e]}});
         sel_mask = sel_mask | (mask_q[e] & {OA_W{lk_vec[e]}});
         sel_perm = sel_perm | (perm_q[e] & {PERM_W{lk_vec[e]}});
      end
   end

   assign any_hit = lk_req && (|lk_vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_done <= 1'b0;
         lk_hit  <= 1'b0;
         lk_oa   <= '0;
         lk_mask <= '0;
         lk_perm <= '0;
      end else begin
         lk_done <= lk_req;
         lk_hit  <= any_hit;
         lk_oa   <= any_hit ? sel_oa   : '0;
         lk_mask <= any_hit ? sel_mask : '0;
         lk_perm <= any_hit ? sel_perm : '0;
      end
   end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int ENTRIES = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_req,
   input logic               lk_done,
   input logic               fill_en,
   input logic               inv_en,
   input logic [1:0]         inv_kind,
   input logic [ENTRIES-1:0] vld_q,
   input logic [ENTRIES-1:0] lk_vec
);

   // R1: reset leaves no valid slot
   p_reset_empty_r1: assert property (@(posedge clk)
      !rst_n |=> (vld_q == '0));

   // R2: result strobe follows the request by one cycle
   p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_done);
   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !lk_done);

   // R4: invalidate-all empties the cache
   p_inv_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && inv_kind == 2'b00) |=> (vld_q == '0));

   // R8: a key is held by at most one slot
   p_unique_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_vec));

   // R9: a fill beside an invalidation never adds a slot
   p_fill_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && fill_en) |=> ($countones(vld_q) <= $countones($past(vld_q))));

   // R11: the no-op command leaves the slots alone
   p_nop_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && inv_kind == 2'b11) |=> $stable(vld_q));

endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .lk_req  (lk_req),
   .lk_done (lk_done),
   .fill_en (fill_en),
   .inv_en  (inv_en),
   .inv_kind(inv_kind),
   .vld_q   (vld_q),
   .lk_vec  (lk_vec)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
   localparam int N  = 8;
   localparam int IW = 16;
   localparam int AW = 48;
   localparam int OW = 48;
   localparam int PW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_req = 1'b0;
   logic [IW-1:0] lk_id = '0;
   logic [AW-1:0] lk_addr = '0;
   logic          lk_done, lk_hit;
   logic [OW-1:0] lk_oa, lk_mask;
   logic [PW-1:0] lk_perm;
   logic          fill_en = 1'b0;
   logic [IW-1:0] fill_id = '0;
   logic [AW-1:0] fill_addr = '0;
   logic [OW-1:0] fill_oa = '0, fill_mask = '0;
   logic [PW-1:0] fill_perm = '0;
   logic          inv_en = 1'b0;
   logic [1:0]    inv_kind = '0;
   logic [IW-1:0] inv_id = '0;
   logic [AW-1:0] inv_addr = '0;

   xlat_cache dut (.*);

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // reference model
   bit            m_vld  [N];
   logic [IW-1:0] m_id   [N];
   logic [AW-1:0] m_addr [N];
   logic [OW-1:0] m_oa   [N];
   logic [OW-1:0] m_mask [N];
   logic [PW-1:0] m_perm [N];
   int            m_rr;

   function automatic int find(input logic [IW-1:0] id, input logic [AW-1:0] a);
      for (int e = 0; e < N; e++)
         if (m_vld[e] && m_id[e] == id && m_addr[e] == a) return e;
      return -1;
   endfunction

   function automatic void model_reset();
      for (int e = 0; e < N; e++) m_vld[e] = 0;
      m_rr = 0;
   endfunction

   function automatic void model_apply();
      if (inv_en) begin
         for (int e = 0; e < N; e++) begin
            case (inv_kind)
               2'b00: m_vld[e] = 0;
               2'b01: if (m_id[e] == inv_id) m_vld[e] = 0;
               2'b10: if (m_id[e] == inv_id && m_addr[e] == inv_addr) m_vld[e] = 0;
               default: ;
            endcase
         end
      end else if (fill_en) begin
         int s;
         s = find(fill_id, fill_addr);
         if (s < 0)
            for (int e = N - 1; e >= 0; e--) if (!m_vld[e]) s = e;
         if (s < 0) begin
            s = m_rr;
            m_rr = (m_rr + 1) % N;
         end
         m_vld[s] = 1; m_id[s] = fill_id; m_addr[s] = fill_addr;
         m_oa[s] = fill_oa; m_mask[s] = fill_mask; m_perm[s] = fill_perm;
      end
   endfunction

   // one cycle: inputs already set at a falling edge
   task automatic cycle(input string tag);
      bit            eh;
      logic [OW-1:0] eoa, emask;
      logic [PW-1:0] ep;
      bit            req;
      int            s;
      req = lk_req;
      @(posedge clk);
      s = find(lk_id, lk_addr);
      eh = (s >= 0);
      eoa = eh ? m_oa[s] : '0;
      emask = eh ? m_mask[s] : '0;
      ep = eh ? m_perm[s] : '0;
      model_apply();
      @(negedge clk);
      if (req) begin
         checks++;
         if (lk_done !== 1'b1 || lk_hit !== eh || lk_oa !== eoa ||
             lk_mask !== emask || lk_perm !== ep) begin
            fails++;
            $display("FAIL %s: done=%b hit=%b oa=%h mask=%h perm=%h expected done=1 hit=%b oa=%h mask=%h perm=%h",
                     tag, lk_done, lk_hit, lk_oa, lk_mask, lk_perm, eh, eoa, emask, ep);
         end
      end
      lk_req = 0; fill_en = 0; inv_en = 0;
   endtask

   task automatic look(input string tag, input logic [IW-1:0] id, input logic [AW-1:0] a);
      lk_req = 1; lk_id = id; lk_addr = a;
      cycle(tag);
   endtask

   task automatic fill(input logic [IW-1:0] id, input logic [AW-1:0] a, input logic [OW-1:0] oa);
      fill_en = 1; fill_id = id; fill_addr = a; fill_oa = oa;
      fill_mask = 48'hfff; fill_perm = oa[1:0];
      cycle("fill");
   endtask

   task automatic inv(input logic [1:0] k, input logic [IW-1:0] id, input logic [AW-1:0] a);
      inv_en = 1; inv_kind = k; inv_id = id; inv_addr = a;
      cycle("inv");
   endtask

   task automatic do_reset();
      rst_n = 0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   function automatic logic [AW-1:0] ka(input int i);
      return 48'h7_0000_0000 | (48'(i) << 12);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      do_reset();

      // R1: empty after reset
      look("R1 empty after reset", 16'h0001, ka(0));
      // R2 hit / R3 partial matches
      fill(16'h0001, ka(0), 48'h1234_5000);
      look("R2 exact key hits", 16'h0001, ka(0));
      look("R3 identifier differs", 16'h0002, ka(0));
      look("R3 address differs", 16'h0001, ka(1));
      // R8 overwrite in place
      fill(16'h0001, ka(0), 48'hbeef_0003);
      look("R8 overwritten data", 16'h0001, ka(0));
      inv(2'b10, 16'h0001, ka(0));
      look("R8 no duplicate left after key removal", 16'h0001, ka(0));
      // R5 / R6 selective invalidation
      fill(16'h0003, ka(1), 48'h1000);
      fill(16'h0003, ka(2), 48'h2001);
      fill(16'h0004, ka(1), 48'h3002);
      inv(2'b10, 16'h0003, ka(1));
      look("R6 key removed", 16'h0003, ka(1));
      look("R6 same id other address kept", 16'h0003, ka(2));
      look("R6 other id same address kept", 16'h0004, ka(1));
      inv(2'b01, 16'h0003, '0);
      look("R5 id entries removed", 16'h0003, ka(2));
      look("R5 other id kept", 16'h0004, ka(1));
      // R11 no-op kind
      inv(2'b11, 16'h0004, ka(1));
      look("R11 no-op keeps entry", 16'h0004, ka(1));
      // R10 lookup right after invalidation
      inv(2'b01, 16'h0004, '0);
      look("R10 removed entry misses next cycle", 16'h0004, ka(1));
      // R9 fill beside invalidation is dropped
      fill_en = 1; fill_id = 16'h0009; fill_addr = ka(5); fill_oa = 48'h5555;
      fill_mask = 48'hfff; fill_perm = 2'b01;
      inv_en = 1; inv_kind = 2'b11; inv_id = '0; inv_addr = '0;
      cycle("R9");
      look("R9 fill with invalidation discarded", 16'h0009, ka(5));
      // R7 lowest free then round-robin
      inv(2'b00, '0, '0);
      for (int i = 0; i < N; i++) fill(16'h0010, ka(i), 48'(i) << 12);
      for (int i = 0; i < N; i++) look("R7 full cache holds all", 16'h0010, ka(i));
      fill(16'h0011, ka(0), 48'hA000);
      look("R7 first replacement evicts slot 0", 16'h0010, ka(0));
      look("R7 slot 1 survives", 16'h0010, ka(1));
      fill(16'h0011, ka(1), 48'hB000);
      look("R7 second replacement evicts slot 1", 16'h0010, ka(1));
      inv(2'b10, 16'h0010, ka(4));
      fill(16'h0012, ka(0), 48'hC000);
      look("R7 freed slot used before round-robin", 16'h0010, ka(2));
      look("R7 new fill present", 16'h0012, ka(0));
      // R4 invalidate all
      inv(2'b00, '0, '0);
      look("R4 all removed", 16'h0011, ka(0));
      // R1 mid-run reset
      fill(16'h0020, ka(3), 48'h7000);
      do_reset();
      look("R1 empty after second reset", 16'h0020, ka(3));

      // random traffic, R2 checks against model
      for (int n = 0; n < 3000; n++) begin
         lk_req = ($urandom_range(9) < 8);
         lk_id = 16'($urandom_range(3));
         lk_addr = ka($urandom_range(3));
         fill_en = ($urandom_range(9) < 4);
         fill_id = 16'($urandom_range(3));
         fill_addr = ka($urandom_range(3));
         fill_oa = 48'($urandom) << 12;
         fill_mask = $urandom_range(1) ? 48'hfff : 48'h1f_ffff;
         fill_perm = 2'($urandom_range(3));
         inv_en = ($urandom_range(15) == 0);
         inv_kind = 2'($urandom_range(3));
         inv_id = 16'($urandom_range(3));
         inv_addr = ka($urandom_range(3));
         cycle("R2 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule